// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block keeps a small queue of 16-bit program words ahead of a processor that runs one instruction at a time. Many of those instructions take several cycles. The block reads the next program word from memory in any cycle where the execution unit leaves the bus idle. The execution unit signals its own operand traffic on a busy line, and that traffic always wins over prefetch. The fetch port is one word wide and has fixed latency: the word for a request made in one cycle arrives on the data input in the next cycle.

Fetched words go into an entry stage and then advance to a head stage, which drives the decoder. A third holding register is filled only when a word arrives while both stages are occupied and nothing moves. The decoder takes the head word by raising a consume strobe. Remaining words then shift up by one position in the same cycle.

A branch or jump raises the redirect strobe with a new program address. The redirect empties all three positions and restarts fetching at that address. Any word still returning for the old address is thrown away.

Top module: `instr_prefetch_q`

## Requirements
- R1: After reset, `instr_valid_o` is low and `fetch_addr_o` equals the parameter RESET_ADDR (0 by default).
- R2: `fetch_req_o` is never high in a cycle where `core_busy_i` or `flush_i` is high.
- R3: The first request after a redirect uses `flush_addr_i`. Each later request uses the previous request address plus 2.
- R4: Words reach the decoder in request order. Each word equals the data returned one cycle after its request.
- R5: After a redirect with the bus free and no consumption, `instr_valid_o` stays low for the next three cycles and is high in the fourth. A word passes through the entry stage before it reaches the head.
- R6: Words requested since the last redirect, minus words consumed, never exceed 3. With no consumption, exactly three requests follow a redirect, and then `fetch_req_o` stays low.
- R7: A word that arrives while both stages are full and no consume happens is kept in the holding register. It is delivered after the two staged words, with no loss.
- R8: A consume while `instr_valid_o` is high removes exactly the head word. A consume while `instr_valid_o` is low has no effect. An untaken head word stays stable.
- R9: A redirect makes `instr_valid_o` low in the next cycle. The word returning for a request made before the redirect is discarded.
- R10: `fetch_req_o` is high in every cycle with `core_busy_i` low, `flush_i` low, and fewer than 3 words requested-and-not-consumed after this cycle's consume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Redirect strobe from branch or jump |
| flush_addr_i | input | 16 | New program address taken with the redirect |
| core_busy_i | input | 1 | Execution unit owns the memory bus this cycle |
| fetch_req_o | output | 1 | Prefetch read issued this cycle |
| fetch_addr_o | output | 16 | Byte address of the prefetch read |
| fetch_data_i | input | 16 | Word returned the cycle after a request |
| consume_i | input | 1 | Decoder takes the head word |
| instr_valid_o | output | 1 | Head stage holds a word |
| instr_o | output | 16 | Head word for the decoder |

## Verification
The assertions check on every cycle the properties that each cycle can show by itself. They cover no requests while the bus is busy, the address stepping by two after each request, no arrival into a full queue without a consume, holding-register occupancy implying both stages are full, an empty head after a redirect, and a stable untaken head. Some behaviours show only across whole scenarios, so only the bench can demonstrate them. These are the exact fill latency after a redirect, the delivered word order through the holding register, the dropping of a word in flight across a redirect, and the precise cycles where opportunistic fetching resumes. The bench checks them against a memory model and an outstanding-word count under directed and seeded random traffic.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned ADDR_W = 16;
  localparam int unsigned SLOTS = 3;
  localparam int unsigned OCC_W = $clog2(SLOTS + 1);
  localparam int unsigned ADDR_STEP = WORD_W / 8;
  localparam int unsigned HEAD = 0;
  localparam int unsigned MID  = 1;
  localparam int unsigned HOLD = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [OCC_W-1:0]  occ_t;
endpackage

// File: rtl/pfq_rst_sync.sv
module pfq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter addr_t RESET_ADDR = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  flush_i,
  input  addr_t flush_addr_i,
  input  logic  busy_i,
  input  occ_t  occ_next_i,
  output logic  req_o,
  output addr_t addr_o,
  output logic  arr_o
);
  addr_t addr_q, addr_d;
  logic  pend_q, pend_d;
  logic  addr_en;

  // next state
  always_comb begin
    req_o   = !busy_i && !flush_i && (occ_next_i < occ_t'(SLOTS));
    arr_o   = pend_q && !flush_i;
    pend_d  = req_o;
    addr_en = flush_i || req_o;
    if (flush_i) addr_d = flush_addr_i;
    else         addr_d = addr_q + addr_t'(ADDR_STEP);
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= RESET_ADDR;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(req_o)) |-> (addr_q == $past(addr_q) + addr_t'(ADDR_STEP))); // R3

  AST_FLUSH_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !arr_o); // R9
endmodule

// File: rtl/pfq_slots.sv
module pfq_slots
  import pfq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  flush_i,
  input  logic  wr_i,
  input  word_t wr_data_i,
  input  logic  take_i,
  output logic  head_vld_o,
  output word_t head_o,
  output occ_t  occ_next_o
);
  logic [SLOTS-1:0] vld_q, vld_d, ld;
  word_t            dat_q [SLOTS];
  word_t            dat_d [SLOTS];
  logic             take, shift;

  // next state
  always_comb begin
    vld_d = vld_q;
    ld    = '0;
    for (int i = 0; i < SLOTS; i++) dat_d[i] = dat_q[i];
    take  = take_i && vld_q[HEAD];
    shift = !vld_q[HEAD] || take;

    if (flush_i) begin
      vld_d = '0;
    end else if (shift) begin
      if (vld_q[MID]) begin
        vld_d[HEAD] = 1'b1;
        dat_d[HEAD] = dat_q[MID];
        ld[HEAD]    = 1'b1;
        if (vld_q[HOLD]) begin
          vld_d[MID]  = 1'b1;
          dat_d[MID]  = dat_q[HOLD];
          ld[MID]     = 1'b1;
          vld_d[HOLD] = wr_i;
          if (wr_i) begin
            dat_d[HOLD] = wr_data_i;
            ld[HOLD]    = 1'b1;
          end
        end else begin
          vld_d[MID] = wr_i;
          if (wr_i) begin
            dat_d[MID] = wr_data_i;
            ld[MID]    = 1'b1;
          end
        end
      end else begin
        vld_d[HEAD] = 1'b0;
        vld_d[HOLD] = 1'b0;
        vld_d[MID]  = wr_i;
        if (wr_i) begin
          dat_d[MID] = wr_data_i;
          ld[MID]    = 1'b1;
        end
      end
    end else begin
      if (vld_q[MID]) begin
        if (wr_i) begin
          vld_d[HOLD] = 1'b1;
          dat_d[HOLD] = wr_data_i;
          ld[HOLD]    = 1'b1;
        end
      end else if (wr_i) begin
        vld_d[MID] = 1'b1;
        dat_d[MID] = wr_data_i;
        ld[MID]    = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (ld[g]) dat_q[g] <= dat_d[g];
    end
  end

  assign head_vld_o = vld_q[HEAD];
  assign head_o     = dat_q[HEAD];
  assign occ_next_o = occ_t'($countones(vld_d));

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !flush_i && !take) |-> !(&vld_q)); // R6

  AST_HOLD_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q[HOLD] |-> (vld_q[HEAD] && vld_q[MID])); // R7
endmodule

// File: rtl/instr_prefetch_q.sv
module instr_prefetch_q
  import pfq_pkg::*;
#(
  parameter addr_t RESET_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              core_busy_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic [WORD_W-1:0] fetch_data_i,
  input  logic              consume_i,
  output logic              instr_valid_o,
  output logic [WORD_W-1:0] instr_o
);
  logic rst_n;
  logic arr;
  occ_t occ_next;

  pfq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  pfq_fetch #(.RESET_ADDR(RESET_ADDR)) i_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .flush_i      (flush_i),
    .flush_addr_i (flush_addr_i),
    .busy_i       (core_busy_i),
    .occ_next_i   (occ_next),
    .req_o        (fetch_req_o),
    .addr_o       (fetch_addr_o),
    .arr_o        (arr)
  );

  pfq_slots i_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .flush_i    (flush_i),
    .wr_i       (arr),
    .wr_data_i  (fetch_data_i),
    .take_i     (consume_i),
    .head_vld_o (instr_valid_o),
    .head_o     (instr_o),
    .occ_next_o (occ_next)
  );

  AST_BUSY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_n)
    core_busy_i |-> !fetch_req_o); // R2

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_n)
    flush_i |=> !instr_valid_o); // R9

  AST_HEAD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (instr_valid_o && !consume_i && !flush_i) |=> (instr_valid_o && $stable(instr_o))); // R8
endmodule

// File: tb/test_instr_prefetch_q.sv
`timescale 1ns/1ps
module test_instr_prefetch_q;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        flush_i;
  logic [15:0] flush_addr_i;
  logic        core_busy_i;
  logic        fetch_req_o;
  logic [15:0] fetch_addr_o;
  logic [15:0] fetch_data_i;
  logic        consume_i;
  logic        instr_valid_o;
  logic [15:0] instr_o;

  int n_chk = 0;
  int n_fail = 0;
  int reqs = 0;
  int consumed = 0;
  logic [15:0] exp_req_addr = 16'h0000;
  logic [15:0] exp_rd = 16'h0000;

  always #5 clk_i = ~clk_i;

  instr_prefetch_q i_instr_prefetch_q (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .flush_addr_i  (flush_addr_i),
    .core_busy_i   (core_busy_i),
    .fetch_req_o   (fetch_req_o),
    .fetch_addr_o  (fetch_addr_o),
    .fetch_data_i  (fetch_data_i),
    .consume_i     (consume_i),
    .instr_valid_o (instr_valid_o),
    .instr_o       (instr_o)
  );

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC35A;
  endfunction

  // memory model: fixed one-cycle latency
  always @(posedge clk_i) begin
    if (fetch_req_o) fetch_data_i <= mem_word(fetch_addr_o);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit fl, input logic [15:0] fa, input bit bz, input bit cs);
    bit take;
    bit exp_req;
    int outstanding;
    @(negedge clk_i);
    flush_i = fl; flush_addr_i = fa; core_busy_i = bz; consume_i = cs;
    #1;
    take = cs && instr_valid_o && !fl;
    if (take) begin
      chk(instr_o == mem_word(exp_rd), "R4 word order/data", {16'h0, instr_o}, {16'h0, mem_word(exp_rd)});
      exp_rd = exp_rd + 16'd2;
      consumed++;
    end
    if (fl || bz) chk(!fetch_req_o, "R2 no fetch when busy/redirect", {31'h0, fetch_req_o}, 32'h0);
    outstanding = reqs - consumed;
    chk(outstanding <= 3, "R6 outstanding limit", outstanding, 3);
    exp_req = !bz && !fl && (outstanding < 3);
    chk(fetch_req_o == exp_req, "R10 opportunistic request", {31'h0, fetch_req_o}, {31'h0, exp_req});
    if (fetch_req_o) begin
      chk(fetch_addr_o == exp_req_addr, "R3 request address", {16'h0, fetch_addr_o}, {16'h0, exp_req_addr});
      exp_req_addr = exp_req_addr + 16'd2;
      reqs++;
    end
    if (fl) begin
      reqs = 0; consumed = 0;
      exp_req_addr = fa; exp_rd = fa;
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_ni = 1'b0; flush_i = 1'b0; flush_addr_i = '0; core_busy_i = 1'b1; consume_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    #1;
    // R1 reset state
    chk(!instr_valid_o, "R1 valid after reset", {31'h0, instr_valid_o}, 32'h0);
    chk(fetch_addr_o == 16'h0000, "R1 fetch address after reset", {16'h0, fetch_addr_o}, 32'h0);

    // R5 fill latency, R6 stop when full, R7 holding register
    step(1, 16'h0100, 0, 0);
    for (int k = 1; k <= 3; k++) begin
      step(0, 16'h0, 0, 0);
      chk(!instr_valid_o, "R5 valid low during fill", {31'h0, instr_valid_o}, 32'h0);
    end
    step(0, 16'h0, 0, 0);
    chk(instr_valid_o, "R5 valid in fourth cycle", {31'h0, instr_valid_o}, 32'h1);
    for (int k = 0; k < 4; k++) begin
      step(0, 16'h0, 0, 0);
      chk(!fetch_req_o, "R6 fetch stopped when full", {31'h0, fetch_req_o}, 32'h0);
    end
    chk(reqs == 3, "R6 three requests after redirect", reqs, 3);
    for (int k = 0; k < 3; k++) begin
      step(0, 16'h0, 1, 1);
    end
    chk(exp_rd == 16'h0106, "R7 three words delivered in order", {16'h0, exp_rd}, 32'h0106);
    step(0, 16'h0, 1, 0);
    chk(!instr_valid_o, "R7 queue empty after three takes", {31'h0, instr_valid_o}, 32'h0);

    // R8 consume while empty is ignored
    step(0, 16'h0, 1, 1);
    step(0, 16'h0, 1, 1);
    chk(!instr_valid_o, "R8 empty stays empty", {31'h0, instr_valid_o}, 32'h0);
    for (int k = 0; k < 5; k++) step(0, 16'h0, 0, 0);
    chk(instr_valid_o && instr_o == mem_word(16'h0106), "R8 next word unaffected by empty consume",
        {16'h0, instr_o}, {16'h0, mem_word(16'h0106)});

    // R2 busy blocks prefetch
    step(1, 16'h2000, 1, 0);
    for (int k = 0; k < 6; k++) begin
      step(0, 16'h0, 1, 0);
      chk(!fetch_req_o && !instr_valid_o, "R2 busy holds off fetch",
          {30'h0, fetch_req_o, instr_valid_o}, 32'h0);
    end

    // R9 word in flight dropped across redirect
    step(1, 16'h3000, 0, 0);
    step(0, 16'h0, 0, 0);
    chk(fetch_req_o, "R9 request for old path issued", {31'h0, fetch_req_o}, 32'h1);
    step(1, 16'h4000, 0, 0);
    step(0, 16'h0, 0, 0);
    chk(!instr_valid_o, "R9 empty after redirect", {31'h0, instr_valid_o}, 32'h0);
    for (int k = 0; k < 4; k++) step(0, 16'h0, 0, 0);
    chk(instr_valid_o && instr_o == mem_word(16'h4000), "R9 first word from new path",
        {16'h0, instr_o}, {16'h0, mem_word(16'h4000)});

    // R9 redirect while full
    step(1, 16'h5000, 0, 0);
    step(0, 16'h0, 0, 0);
    chk(!instr_valid_o, "R9 redirect empties full queue", {31'h0, instr_valid_o}, 32'h0);

    // seeded random traffic
    for (int k = 0; k < 3000; k++) begin
      bit fl;
      logic [15:0] fa;
      fl = ($urandom % 40) == 0;
      fa = 16'($urandom) & 16'hFFFE;
      step(fl, fa, ($urandom % 10) < 3, ($urandom % 2) == 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule